// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block collects interrupt requests from a group of physical lines and tells a processor core which priority level, if any, it should service next. Each line has its own latching mode. A level-mode line's pending bit follows its input. An edge-mode line's pending bit is set by a rising edge and stays set until software clears it.

A software-written enable register selects which pending lines may take part. The lines are sorted into priority levels by a configuration mask for each level. The block scans the levels from the top down and picks the highest one that both contains an enabled pending line and sits strictly above the core's current interrupt level. The result is a registered level number and a request flag for the core. Software can also set or clear the pending bits of edge-mode lines through write strobes.

Only the lowest `NUM_LINES` of the `IRQ_W` physical lines are implemented. The remaining lines are inert.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An implemented line whose input goes high gets its pending bit set. With the line enabled and its level above the current level, the request appears after the next clock edge.
- R2: A line whose `line_is_level` bit is 1 (level mode) has its pending bit cleared when its input goes low. A line whose bit is 0 (edge mode) keeps its pending bit after its input falls.
- R3: Lines with an index at or above `NUM_LINES` are ignored. Their inputs, set strobes and clear strobes change no state, even when they appear in a level mask and are enabled.
- R4: Only lines set in both the pending register and the enable register take part. A write to `en_wr` with `en_wdata` replaces the enable register.
- R5: Levels are numbered 1 to `NUM_LEVELS`. The mask for level L occupies bits `[(L-1)*IRQ_W +: IRQ_W]` of `level_mask`. The highest level whose mask meets an enabled pending line is reported.
- R6: A level is reported only if it is strictly greater than `cur_level`. A level equal to `cur_level` is not taken.
- R7: When no level qualifies, `pend_level` is 0 and `core_req` is low. When one does, `core_req` is high and `pend_level` is that level.
- R8: The outputs are registered. A change of the inputs, the enable write or `cur_level` before a clock edge is visible after that edge.
- R9: A 1 in `clr_data` with `clr_wr` high clears the pending bit of an edge-mode line. It has no effect on a level-mode line whose input is high.
- R10: A 1 in `set_data` with `set_wr` high sets the pending bit of an edge-mode line. It is ignored for level-mode lines. If set and clear hit the same edge-mode bit together, set wins.
- R11: During and right after reset, `pend_level` is 0, `core_req` is low, and the pending and enable registers are zero.
- R12: An edge-mode line latches only on a low-to-high transition. A line held high after its pending bit is cleared does not latch again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | IRQ_W | Interrupt request lines |
| line_is_level | input | IRQ_W | Per-line mode: 1 level, 0 edge |
| level_mask | input | NUM_LEVELS*IRQ_W | Line membership mask for each level |
| cur_level | input | LVL_W | Core's current interrupt level |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | IRQ_W | Enable register write data |
| set_wr | input | 1 | Software set strobe |
| set_data | input | IRQ_W | Lines to set (edge mode only) |
| clr_wr | input | 1 | Software clear strobe |
| clr_data | input | IRQ_W | Lines to clear (edge mode only) |
| pend_level | output | LVL_W | Registered highest qualifying level, 0 if none |
| core_req | output | 1 | Registered interrupt request to the core |

## Verification
The assertions check the following properties on every cycle:
- The reported level is always above the previous cycle's current level whenever a request is raised.
- No request is raised while the enabled pending set is empty.
- A level-mode pending bit mirrors its input one cycle later.
- An edge-mode bit never drops without a clear strobe.

The following properties can only be shown by the bench's scenarios:
- The ordering between levels.
- The inertness of lines above the implemented count.
- Set winning over clear.
- The absence of relatching on a held-high input.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic {
      LINE_EDGE  = 1'b0,
      LINE_LEVEL = 1'b1
   } line_mode_e;

   function automatic int level_bits(input int levels);
      return (levels < 1) ? 1 : $clog2(levels + 1);
   endfunction

endpackage

// File: rtl/pic_line_latch.sv
module pic_line_latch
   import pic_pkg::*;
#(
   parameter int IRQ_W     = 8,
   parameter int NUM_LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] irq_in,
   input  logic [IRQ_W-1:0] line_is_level,
   input  logic [IRQ_W-1:0] sw_set,
   input  logic [IRQ_W-1:0] sw_clr,
   output logic [IRQ_W-1:0] pend_d,
   output logic [IRQ_W-1:0] pend_q
);

   for (genvar i = 0; i < IRQ_W; i++) begin : g_line
      if (i < NUM_LINES) begin : g_impl
         logic       prev_q;
         logic       rise;
         line_mode_e mode;

         assign mode = line_mode_e'(line_is_level[i]);
         assign rise = irq_in[i] & ~prev_q;

         always_comb begin
            if (mode == LINE_LEVEL)
               pend_d[i] = irq_in[i];
            else
               pend_d[i] = (pend_q[i] & ~sw_clr[i]) | rise | sw_set[i];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q    <= 1'b0;
               pend_q[i] <= 1'b0;
            end else begin
               prev_q    <= irq_in[i];
               pend_q[i] <= pend_d[i];
            end
         end

         // R2
         level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && line_is_level[i] && $stable(line_is_level[i]))
               |-> (pend_q[i] == $past(irq_in[i])));

         // R2
         edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !line_is_level[i] && !$past(line_is_level[i])
               && $past(pend_q[i]) && !$past(sw_clr[i])) |-> pend_q[i]);
      end else begin : g_absent
         logic unused_bits;
         assign unused_bits = ^{irq_in[i], line_is_level[i], sw_set[i], sw_clr[i]};
         assign pend_d[i]   = 1'b0;
         assign pend_q[i]   = 1'b0;
      end
   end

endmodule

// File: rtl/pic_level_resolver.sv
module pic_level_resolver #(
   parameter int IRQ_W      = 8,
   parameter int NUM_LEVELS = 3,
   parameter int LVL_W      = 2
) (
   input  logic [IRQ_W-1:0]            eff,
   input  logic [NUM_LEVELS*IRQ_W-1:0] level_mask,
   input  logic [LVL_W-1:0]            cur_level,
   output logic [LVL_W-1:0]            win_level,
   output logic                        win_hit
);

   logic [NUM_LEVELS:1] lvl_hit;

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
      assign lvl_hit[l] = (|(level_mask[(l-1)*IRQ_W +: IRQ_W] & eff))
                          && (l > int'(cur_level));
   end

   always_comb begin
      win_level = '0;
      win_hit   = 1'b0;
      for (int l = NUM_LEVELS; l >= 1; l--) begin
         if (!win_hit && lvl_hit[l]) begin
            win_level = LVL_W'(l);
            win_hit   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int IRQ_W      = 8,
   parameter int NUM_LINES  = 6,
   parameter int NUM_LEVELS = 3,
   parameter int LVL_W      = level_bits(NUM_LEVELS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IRQ_W-1:0]            irq_in,
   input  logic [IRQ_W-1:0]            line_is_level,
   input  logic [NUM_LEVELS*IRQ_W-1:0] level_mask,
   input  logic [LVL_W-1:0]            cur_level,
   input  logic                        en_wr,
   input  logic [IRQ_W-1:0]            en_wdata,
   input  logic                        set_wr,
   input  logic [IRQ_W-1:0]            set_data,
   input  logic                        clr_wr,
   input  logic [IRQ_W-1:0]            clr_data,
   output logic [LVL_W-1:0]            pend_level,
   output logic                        core_req
);

   localparam int MIN_LVL_W = level_bits(NUM_LEVELS);

   if (NUM_LINES < 1 || NUM_LINES > IRQ_W) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..IRQ_W");
   end
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("NUM_LEVELS must be at least 1");
   end
   if (LVL_W < MIN_LVL_W) begin : g_bad_lvl_w
      $error("LVL_W too narrow for NUM_LEVELS");
   end

   logic [IRQ_W-1:0] sw_set, sw_clr;
   logic [IRQ_W-1:0] pend_d, pend_q;
   logic [IRQ_W-1:0] en_d, en_q;
   logic [IRQ_W-1:0] eff_d, eff_q;
   logic [LVL_W-1:0] win_level;
   logic             win_hit;

   assign sw_set = set_wr ? set_data : '0;
   assign sw_clr = clr_wr ? clr_data : '0;
   assign en_d   = en_wr ? en_wdata : en_q;
   assign eff_d  = pend_d & en_d;

   pic_line_latch #(
      .IRQ_W     (IRQ_W),
      .NUM_LINES (NUM_LINES)
   ) u_latch (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_in        (irq_in),
      .line_is_level (line_is_level),
      .sw_set        (sw_set),
      .sw_clr        (sw_clr),
      .pend_d        (pend_d),
      .pend_q        (pend_q)
   );

   pic_level_resolver #(
      .IRQ_W      (IRQ_W),
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) u_resolve (
      .eff        (eff_d),
      .level_mask (level_mask),
      .cur_level  (cur_level),
      .win_level  (win_level),
      .win_hit    (win_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= '0;
         eff_q      <= '0;
         pend_level <= '0;
         core_req   <= 1'b0;
      end else begin
         en_q       <= en_d;
         eff_q      <= eff_d;
         pend_level <= win_level;
         core_req   <= win_hit;
      end
   end

   logic unused_pend;
   assign unused_pend = ^pend_q;

   // R6
   above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && core_req) |-> (pend_level > $past(cur_level)));

   // R7
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_q == '0) |-> (!core_req && pend_level == '0));

   // R7
   req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (pend_level != '0));

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

   localparam int IRQ_W  = 8;
   localparam int NLINES = 6;
   localparam int NLVL   = 3;
   localparam int LW     = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [IRQ_W-1:0]  irq_in;
   logic [IRQ_W-1:0]  line_is_level;
   logic [NLVL*IRQ_W-1:0] level_mask;
   logic [LW-1:0]     cur_level;
   logic              en_wr, set_wr, clr_wr;
   logic [IRQ_W-1:0]  en_wdata, set_data, clr_data;
   logic [LW-1:0]     pend_level;
   logic              core_req;

   always #4 clk = ~clk;

   prio_irq_ctrl #(
      .IRQ_W      (IRQ_W),
      .NUM_LINES  (NLINES),
      .NUM_LEVELS (NLVL),
      .LVL_W      (LW)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_in        (irq_in),
      .line_is_level (line_is_level),
      .level_mask    (level_mask),
      .cur_level     (cur_level),
      .en_wr         (en_wr),
      .en_wdata      (en_wdata),
      .set_wr        (set_wr),
      .set_data      (set_data),
      .clr_wr        (clr_wr),
      .clr_data      (clr_data),
      .pend_level    (pend_level),
      .core_req      (core_req)
   );

   typedef struct {
      logic [LW-1:0] lvl;
      logic          req;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // Monitor: pops one expected item per cycle, away from the active edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if (pend_level !== e.lvl || core_req !== e.req) begin
            n_fail++;
            $display("FAIL %s: level=%0d req=%0b expected level=%0d req=%0b",
                     e.tag, pend_level, core_req, e.lvl, e.req);
         end
      end
   end

   // Driver: one clock step, then queue what the outputs must show.
   task automatic step(input string tag, input int lvl, input bit req);
      exp_t e;
      @(posedge clk);
      #1;
      en_wr  = 1'b0;
      set_wr = 1'b0;
      clr_wr = 1'b0;
      e.lvl = LW'(lvl);
      e.req = req;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr_en(input logic [IRQ_W-1:0] d);
      en_wr = 1'b1; en_wdata = d;
   endtask
   task automatic wr_set(input logic [IRQ_W-1:0] d);
      set_wr = 1'b1; set_data = d;
   endtask
   task automatic wr_clr(input logic [IRQ_W-1:0] d);
      clr_wr = 1'b1; clr_data = d;
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n         = 1'b0;
      irq_in        = '0;
      line_is_level = 8'b0001_0101;            // lines 0,2,4 level mode
      level_mask    = {8'b1111_0000,           // level 3: lines 4,5 (+6,7 inert)
                       8'b0000_1100,           // level 2: lines 2,3
                       8'b0000_0011};          // level 1: lines 0,1
      cur_level     = '0;
      en_wr = 1'b0; set_wr = 1'b0; clr_wr = 1'b0;
      en_wdata = '0; set_data = '0; clr_data = '0;
      repeat (3) @(posedge clk);
      #1;
      n_run++;
      if (pend_level !== '0 || core_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R11: level=%0d req=%0b expected level=0 req=0",
                  pend_level, core_req);
      end
      irq_in[0] = 1'b1;                         // R11: enable reset to zero
      step("R11 enable zero after reset", 0, 0);
      rst_n = 1'b1;
      irq_in[0] = 1'b0;
      wr_en(8'hFF);
      step("R7 enabled but idle", 0, 0);
      irq_in[0] = 1'b1;
      step("R1 R8 level line request", 1, 1);
      irq_in[0] = 1'b0;
      step("R2 level line clears", 0, 0);
      irq_in[1] = 1'b1;
      step("R1 edge line request", 1, 1);
      irq_in[1] = 1'b0;
      step("R2 edge line stays latched", 1, 1);
      irq_in[2] = 1'b1;
      step("R5 level 2 over level 1", 2, 1);
      irq_in[5] = 1'b1;
      step("R5 level 3 highest", 3, 1);
      irq_in[5] = 1'b0;
      cur_level = 2'd3;
      step("R6 nothing above current 3", 0, 0);
      cur_level = 2'd2;
      step("R6 R8 level 3 above current 2", 3, 1);
      cur_level = 2'd1;
      wr_clr(8'b0010_0000);
      step("R9 clear edge line 5", 2, 1);
      cur_level = 2'd2;
      step("R6 equal level not taken", 0, 0);
      cur_level = 2'd0;
      wr_clr(8'b0000_0100);
      step("R9 clear ignored on high level line", 2, 1);
      irq_in[2] = 1'b0;
      step("R2 level line 2 drops", 1, 1);
      wr_en(8'hFD);
      step("R4 disabled pending line", 0, 0);
      wr_en(8'hFF);
      step("R4 re-enabled pending line", 1, 1);
      wr_clr(8'b0000_0010);
      step("R9 clear edge line 1", 0, 0);
      irq_in[7:6] = 2'b11;
      wr_set(8'b1100_0000);
      step("R3 inert lines set", 0, 0);
      irq_in[7:6] = 2'b00;
      wr_clr(8'b1100_0000);
      step("R3 inert lines still quiet", 0, 0);
      wr_set(8'b0000_1000);
      step("R10 sw set edge line 3", 2, 1);
      wr_clr(8'b0000_1000);
      wr_set(8'b0000_0001);
      step("R10 sw set ignored on level line", 0, 0);
      wr_set(8'b0000_1000);
      wr_clr(8'b0000_1000);
      step("R10 set wins over clear", 2, 1);
      wr_clr(8'b0000_1000);
      step("R9 clear line 3", 0, 0);
      irq_in[3] = 1'b1;
      step("R12 rising edge latches", 2, 1);
      wr_clr(8'b0000_1000);
      step("R12 clear while held high", 0, 0);
      step("R12 no relatch while high", 0, 0);
      irq_in[3] = 1'b0;
      step("R12 fall does not latch", 0, 0);
      irq_in[3] = 1'b1;
      irq_in[0] = 1'b1;
      step("R12 R5 new rise latches", 2, 1);
      irq_in[3] = 1'b0;
      wr_clr(8'b0000_1000);
      step("R5 lower level remains", 1, 1);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule